// File: doc/BRIEF.md
# Set/Clear GPIO Port with Tristate Control

This block is a 32-pin general-purpose I/O port behind a small word-addressed register interface. Software moves a pin high or low by writing a mask to one of two drive registers. Each pin named in such a write also starts driving. A third mask register releases named pins back to input mode and turns their drivers off. A status word returns the pad levels after they pass through a two-flop synchronizer.

Input sampling starts in a locked condition. A two-state machine gates the status word. The machine resets into `ARM_GATED`, where the status word reads as all zeros whatever the pads show. Any write to the arming register moves it to `ARM_LIVE`; the value written is ignored. `ARM_LIVE` holds until the next reset, so no later access returns the machine to `ARM_GATED`. The port drives per-pin output enables and output levels to the pad ring. Pad cells and interrupt routing sit outside the block.

Top module: `gpsc_port`

## Requirements
- R1: After reset, `pad_oe`, `pad_out` and `rdata` are all zero.
- R2: A write to offset 0x00 sets `pad_out[n]` to 1 for every bit n that is 1 in `wdata`. It leaves the other bits unchanged. The new value is visible after the clock edge that accepts the write.
- R3: A write to offset 0x04 clears `pad_out[n]` to 0 for every bit n that is 1 in `wdata`. It leaves the other bits unchanged.
- R4: A write to offset 0x00 or 0x04 sets `pad_oe[n]` to 1 for every bit that is 1 in `wdata`, in the same edge as the level change. Other enable bits keep their values.
- R5: A write to offset 0x08 clears `pad_oe[n]` for every bit that is 1 in `wdata`. It does not change `pad_out` or the other enable bits.
- R6: A read (`rd`=1) registers its result into `rdata` at the accepting edge. When `rd` is 0, `rdata` holds its value.
- R7: While the machine is in `ARM_GATED`, a read of offset 0x0C returns 0 for every pad pattern.
- R8: Any write to offset 0x10 moves the machine to `ARM_LIVE`, whatever the data. A read of offset 0x0C then returns the pad levels with pin n at bit n, delayed by two synchronizer stages.
- R9: A read of any offset other than 0x0C, including unmapped offsets, returns 0.
- R10: A write to offset 0x0C or to an unmapped offset changes neither `pad_oe` nor `pad_out`.
- R11: When `rd` and `wr` are both 1 in one cycle, the write takes its normal effect. The read returns the value its offset gives under R7 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 32 | Write mask |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output level |

## Verification
The read and write strobes share one address, so the only access collision is `rd` and `wr` raised together on one offset. The bench provokes it in three ways: a drive write read back as zero, a write to the read-only status offset whose read returns the pad levels, and an arming write that reads zero. For each case the bench checks that the pad outputs follow the write rule and `rdata` follows the read rule. The pads loop back through a bench model, so the status word also reflects driven pins. The checks are spread among random drive, release and arming traffic.

// File: rtl/gpsc_pkg.sv
package gpsc_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_SET = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CLR = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TRI = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_PIN = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_ARM = 5'h10;

    typedef enum logic [2:0] {
        SEL_SET  = 3'd0,
        SEL_CLR  = 3'd1,
        SEL_TRI  = 3'd2,
        SEL_PIN  = 3'd3,
        SEL_ARM  = 3'd4,
        SEL_NONE = 3'd5
    } reg_sel_e;

    typedef enum logic {
        ARM_GATED = 1'b0,
        ARM_LIVE  = 1'b1
    } arm_state_e;
endpackage

// File: rtl/gpsc_decode.sv
module gpsc_decode
    import gpsc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              set_we,
    output logic              clr_we,
    output logic              tri_we,
    output logic              arm_we,
    output logic              pin_rd
);
    reg_sel_e sel;

    always_comb begin
        unique case (addr)
            OFS_SET: sel = SEL_SET;
            OFS_CLR: sel = SEL_CLR;
            OFS_TRI: sel = SEL_TRI;
            OFS_PIN: sel = SEL_PIN;
            OFS_ARM: sel = SEL_ARM;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        set_we = wr && (sel == SEL_SET);
        clr_we = wr && (sel == SEL_CLR);
        tri_we = wr && (sel == SEL_TRI);
        arm_we = wr && (sel == SEL_ARM);
        pin_rd = rd && (sel == SEL_PIN);
    end
endmodule

// File: rtl/gpsc_sync.sv
module gpsc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (g == 0) begin
                stage_q[g] <= async_in;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpsc_arm_fsm.sv
module gpsc_arm_fsm
    import gpsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_we,
    output logic sample_en
);
    arm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_GATED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_GATED: if (arm_we) state_d = ARM_LIVE;
            ARM_LIVE:  state_d = ARM_LIVE;
        endcase
    end

    always_comb begin
        sample_en = (state_q == ARM_LIVE);
    end
endmodule

// File: rtl/gpsc_drive_regs.sv
module gpsc_drive_regs #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              tri_we,
    input  logic [N_PINS-1:0] wmask,
    output logic [N_PINS-1:0] lvl_q,
    output logic [N_PINS-1:0] oe_q
);
    logic [N_PINS-1:0] lvl_d, oe_d;

    always_comb begin
        lvl_d = lvl_q;
        oe_d  = oe_q;
        if (set_we) begin
            lvl_d = lvl_q | wmask;
            oe_d  = oe_q | wmask;
        end else if (clr_we) begin
            lvl_d = lvl_q & ~wmask;
            oe_d  = oe_q | wmask;
        end else if (tri_we) begin
            oe_d  = oe_q & ~wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            oe_q  <= '0;
        end else begin
            lvl_q <= lvl_d;
            oe_q  <= oe_d;
        end
    end
endmodule

// File: rtl/gpsc_read_mux.sv
module gpsc_read_mux #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              pin_rd,
    input  logic              sample_en,
    input  logic [N_PINS-1:0] pin_sync,
    output logic [N_PINS-1:0] rdata_q
);
    logic [N_PINS-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (pin_rd && sample_en) rd_val = pin_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_val;
    end
endmodule

// File: rtl/gpsc_port.sv
module gpsc_port
    import gpsc_pkg::*;
#(
    parameter int N_PINS      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [N_PINS-1:0] rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out
);
    logic set_we, clr_we, tri_we, arm_we, pin_rd, sample_en;
    logic [N_PINS-1:0] pin_sync;

    gpsc_decode u_dec (
        .addr   (addr),
        .wr     (wr),
        .rd     (rd),
        .set_we (set_we),
        .clr_we (clr_we),
        .tri_we (tri_we),
        .arm_we (arm_we),
        .pin_rd (pin_rd)
    );

    gpsc_drive_regs #(.N_PINS(N_PINS)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we),
        .clr_we (clr_we),
        .tri_we (tri_we),
        .wmask  (wdata),
        .lvl_q  (pad_out),
        .oe_q   (pad_oe)
    );

    gpsc_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpsc_arm_fsm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_we    (arm_we),
        .sample_en (sample_en)
    );

    gpsc_read_mux #(.N_PINS(N_PINS)) u_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (rd),
        .pin_rd    (pin_rd),
        .sample_en (sample_en),
        .pin_sync  (pin_sync),
        .rdata_q   (rdata)
    );
endmodule

// File: rtl/gpsc_port_chk.sv
module gpsc_port_chk
    import gpsc_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [N_PINS-1:0] wdata,
    input logic              wr,
    input logic              rd,
    input logic [N_PINS-1:0] rdata,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] pad_out
);
    logic seen_arm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        seen_arm <= 1'b0;
        else if (wr && addr == OFS_ARM)    seen_arm <= 1'b1;
    end

    // R2
    set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_SET) |=> ((pad_out & $past(wdata)) == $past(wdata)));

    // R3
    clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_CLR) |=> ((pad_out & $past(wdata)) == '0));

    // R4
    drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == OFS_SET || addr == OFS_CLR)) |=> ((pad_oe & $past(wdata)) == $past(wdata)));

    // R5
    tri_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_TRI) |=> (((pad_oe & $past(wdata)) == '0) && $stable(pad_out)));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R7
    gated_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFS_PIN && !seen_arm) |=> (rdata == '0));

    // R9
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr != OFS_PIN) |=> (rdata == '0));

    // R10
    ro_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != OFS_SET && addr != OFS_CLR && addr != OFS_TRI)
        |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpsc_port gpsc_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr      (wr),
    .rd      (rd),
    .rdata   (rdata),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
);

// File: tb/gpsc_port_test.sv
module gpsc_port_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_SET = 5'h00, A_CLR = 5'h04, A_TRI = 5'h08,
                           A_PIN = 5'h0C, A_ARM = 5'h10, A_BAD = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata, pad_in, pad_oe, pad_out;
    logic [31:0] ext_lvl = '0;

    logic [31:0] exp_out = '0, exp_oe = '0;
    bit          armed = 1'b0;
    bit          done = 1'b0;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

    gpsc_port uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [31:0] pin_view();
        return armed ? ((exp_oe & exp_out) | (~exp_oe & ext_lvl)) : 32'h0;
    endfunction

    function automatic logic [31:0] read_expect(logic [4:0] a);
        return (a == A_PIN) ? pin_view() : 32'h0;
    endfunction

    task automatic apply_model(logic [4:0] a, logic [31:0] d);
        case (a)
            A_SET: begin exp_out |= d;  exp_oe |= d; end
            A_CLR: begin exp_out &= ~d; exp_oe |= d; end
            A_TRI: exp_oe &= ~d;
            A_ARM: armed = 1'b1;
            default: ;
        endcase
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pads(string tag);
        check({tag, " pad_out"}, pad_out, exp_out);
        check({tag, " pad_oe"}, pad_oe, exp_oe);
    endtask

    // one access cycle; starts and ends at a falling edge
    task automatic access(logic [4:0] a, logic [31:0] d, bit do_wr, bit do_rd);
        addr = a; wdata = d; wr = do_wr; rd = do_rd;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        if (do_wr) apply_model(a, d);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic rand_op(bit allow_arm);
        int unsigned k;
        logic [31:0] d;
        k = $urandom_range(0, allow_arm ? 7 : 6);
        d = $urandom();
        case (k)
            0: begin access(A_SET, d, 1, 0); check_pads("R2 R4 set"); end
            1: begin access(A_CLR, d, 1, 0); check_pads("R3 R4 clr"); end
            2: begin access(A_TRI, d, 1, 0); check_pads("R5 tri"); end
            3: begin
                ext_lvl = $urandom();
                settle();
                access(A_PIN, 32'h0, 0, 1);
                check(armed ? "R8 pin read" : "R7 gated read", rdata, pin_view());
            end
            4: begin
                access(($urandom_range(0, 1) != 0) ? A_BAD : A_SET, 32'h0, 0, 1);
                check("R9 other read", rdata, 32'h0);
            end
            5: begin
                access(($urandom_range(0, 1) != 0) ? A_BAD : A_PIN, d, 1, 0);
                check_pads("R10 ignored write");
            end
            6: begin
                logic [31:0] held;
                held = rdata;
                access(A_SET, 32'h0, 0, 0);
                check("R6 rdata hold", rdata, held);
            end
            default: begin access(A_ARM, d, 1, 0); check_pads("R8 arm write"); end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset pad_out", pad_out, 32'h0);
        check("R1 reset pad_oe", pad_oe, 32'h0);
        check("R1 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 gated: pads all high but status must read zero
        ext_lvl = 32'hFFFF_FFFF;
        settle();
        access(A_PIN, 32'h0, 0, 1);
        check("R7 gated all-ones pads", rdata, 32'h0);

        // R2/R4 corner masks
        access(A_SET, 32'hFFFF_FFFF, 1, 0);
        check_pads("R2 R4 set all");
        access(A_CLR, 32'h8000_0001, 1, 0);
        check_pads("R3 clr edge pins");
        access(A_TRI, 32'h0000_0000, 1, 0);
        check_pads("R5 tri zero mask");
        access(A_TRI, 32'hFFFF_0000, 1, 0);
        check_pads("R5 tri upper half");

        for (int i = 0; i < 150; i++) rand_op(1'b0);

        // R8 arm with a zero data word
        access(A_ARM, 32'h0, 1, 0);
        ext_lvl = 32'hA5A5_0F0F;
        settle();
        access(A_PIN, 32'h0, 0, 1);
        check("R8 first live read", rdata, pin_view());

        // R11 collisions: read and write in the same cycle
        access(A_SET, 32'h0000_FF00, 1, 1);
        check_pads("R11 set during read");
        check("R11 set offset read", rdata, 32'h0);
        settle();
        access(A_PIN, 32'hFFFF_FFFF, 1, 1);
        check_pads("R11 ro write during read");
        check("R11 pin read with write", rdata, pin_view());
        access(A_ARM, 32'h1234_5678, 1, 1);
        check("R11 arm offset read", rdata, 32'h0);

        for (int i = 0; i < 400; i++) rand_op(1'b1);

        // R10 unmapped write after everything
        access(A_BAD, 32'hFFFF_FFFF, 1, 0);
        check_pads("R10 unmapped write");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule